// File: doc/BRIEF.md
# Shared Timer/Watchdog Prescaler

This block holds one 8-bit prescaler that serves one of two clients at a time. When it is given to the timer, it sits between the timer's count source and an 8-bit up-counter. When it is given to the watchdog, it sits after a small base counter and turns base-period expiries into watchdog timeouts. A control byte selects the timer's count source, which edge of the external pin counts, which client owns the prescaler, and a 3-bit rate.

The client that does not own the prescaler runs undivided. The divide ratio depends on the owner. On the timer side the ratio runs from 1:2 to 1:256. On the watchdog side it runs from 1:1 to 1:128. The timer can only count at 1:1 when the prescaler belongs to the watchdog. The CPU can load the timer directly, and that load restarts the prescaler. A watchdog clear restarts the base counter, and it also restarts the prescaler when the watchdog owns it.

Top module: `tick_prescaler_top`

## Requirements
- R1: After a synchronous reset the control byte reads 8'hFF, the timer reads 0, and neither output pulse is high.
- R2: A write stores the whole control byte, and the byte reads back on `ctl_value`. The fields are: bit 5 picks the count source (1 = external pin, 0 = instruction tick); bit 4 picks the edge (1 = falling, 0 = rising); bit 3 picks the owner (1 = watchdog, 0 = timer); bits 2:0 give the rate. Bits 7 and 6 are only stored.
- R3: With bit 5 at 0, the timer counts `cyc_tick` pulses, and activity on the external pin has no effect.
- R4: With bit 5 at 1 and bit 4 at 0, the timer counts rising edges of `ext_pin` after a two-stage synchronizer, and `cyc_tick` has no effect.
- R5: With bit 5 at 1 and bit 4 at 1, the timer counts falling edges of `ext_pin` only.
- R6: With bit 3 at 0, the timer advances once per 2^(rate+1) source events, counted from the last prescaler restart.
- R7: With bit 3 at 1, the timer advances on every source event.
- R8: The base counter expires once every WDT_BASE `wdt_tick` pulses. With bit 3 at 0, each expiry raises `wdt_timeout` for one cycle. With bit 3 at 1, one timeout occurs per 2^rate expiries.
- R9: A timer write loads `tmr_wdata` and restarts the prescaler. If a count event arrives in the same cycle, the write wins and that event is dropped.
- R10: When counting takes the timer from 8'hFF to 0, `tmr_ovf` goes high for exactly one cycle. A write never raises it.
- R11: `wdt_clr` restarts the base counter, and it restarts the prescaler only when bit 3 is 1. A `wdt_tick` in the same cycle as `wdt_clr` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| tmr_wr | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write data |
| wdt_clr | input | 1 | Watchdog clear command |
| cyc_tick | input | 1 | Instruction-cycle tick, one clock wide |
| ext_pin | input | 1 | Asynchronous external count pin |
| wdt_tick | input | 1 | Watchdog base tick, one clock wide |
| ctl_value | output | 8 | Current control byte |
| tmr_value | output | 8 | Current timer count |
| tmr_ovf | output | 1 | One-cycle pulse on timer wrap by counting |
| wdt_timeout | output | 1 | One-cycle watchdog timeout pulse |

## Verification
Two sets of events can land in the same clock cycle. The first is a timer write and a count event. The bench raises `tmr_wr` and `cyc_tick` on the same edge, once at 1:1 and once at 1:2 after one event has already entered the prescaler. It then judges by the count after one further event: the timer must hold the written value, and the prescaler must have been emptied. The second is a watchdog clear and a base tick. The bench raises both together one tick short of expiry and checks that the next timeout arrives only after a full base period has passed.

// File: rtl/psc_pkg.sv
package psc_pkg;

    localparam int CTL_W   = 8;
    localparam int RATE_W  = 3;
    localparam int PRE_W   = 8;
    localparam int TMR_W   = 8;

    typedef struct packed {
        logic              pull_off;
        logic              irq_edge;
        logic              src_ext;
        logic              edge_fall;
        logic              own_wdt;
        logic [RATE_W-1:0] rate;
    } ctl_t;

    localparam ctl_t CTL_RESET = ctl_t'({CTL_W{1'b1}});

    // mask of low prescaler bits that must all be set for a pass
    function automatic logic [PRE_W-1:0] rate_mask(input logic [RATE_W-1:0] rate,
                                                   input logic own_wdt);
        logic [PRE_W:0] span;
        span = own_wdt ? ((PRE_W+1)'(1) << rate) : ((PRE_W+1)'(2) << rate);
        return PRE_W'(span - (PRE_W+1)'(1));
    endfunction

endpackage

// File: rtl/psc_pin_edge.sv
module psc_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b0;
                    else     sync_q[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[i] <= 1'b0;
                    else     sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= sync_q[SYNC_STAGES-1];
    end

    logic cur;
    assign cur    = sync_q[SYNC_STAGES-1];
    assign edge_o = fall_sel ? (last_q & ~cur) : (~last_q & cur);

    // R4
    edge_needs_change_chk: assert property (@(posedge clk) disable iff (rst)
        edge_o |=> (last_q != $past(last_q)));

endmodule

// File: rtl/psc_divider.sv
module psc_divider #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         evt,
    input  logic [W-1:0] mask,
    output logic         pass_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)      cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (evt) cnt_q <= cnt_q + 1'b1;
    end

    assign pass_o = evt & ~clr & ((cnt_q & mask) == mask);

    // R9
    restart_empties_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));

    // R6
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !evt) |=> $stable(cnt_q));

endmodule

// File: rtl/psc_timer.sv
module psc_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         ovf
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= inc & ~wr & (value == TOP);
            if (wr)       value <= wdata;
            else if (inc) value <= value + 1'b1;
        end
    end

    // R9
    write_loads_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> (value == $past(wdata)));

    // R10
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (value == '0 && $past(value) == TOP));

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> !ovf);

    // R3
    no_event_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr && !inc) |=> $stable(value));

endmodule

// File: rtl/psc_wdt_base.sv
module psc_wdt_base #(
    parameter int BASE = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic expire_o
);
    localparam int CW = (BASE > 1) ? $clog2(BASE) : 1;
    localparam logic [CW-1:0] LAST = CW'(BASE - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt_q <= '0;
        else if (tick)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign expire_o = tick & ~clr & (cnt_q == LAST);

    // R11
    clear_restarts_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/tick_prescaler_top.sv
module tick_prescaler_top
    import psc_pkg::*;
#(
    parameter int WDT_BASE    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             tmr_wr,
    input  logic [TMR_W-1:0] tmr_wdata,
    input  logic             wdt_clr,
    input  logic             cyc_tick,
    input  logic             ext_pin,
    input  logic             wdt_tick,
    output logic [CTL_W-1:0] ctl_value,
    output logic [TMR_W-1:0] tmr_value,
    output logic             tmr_ovf,
    output logic             wdt_timeout
);
    ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= CTL_RESET;
        else if (ctl_wr) ctl_q <= ctl_t'(ctl_wdata);
    end
    assign ctl_value = ctl_q;

    logic pin_edge, tmr_src, base_exp;
    logic pre_evt, pre_clr, pre_pass, tmr_inc;
    logic [PRE_W-1:0] mask;

    psc_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
        .clk(clk), .rst(rst), .pin(ext_pin),
        .fall_sel(ctl_q.edge_fall), .edge_o(pin_edge)
    );

    assign tmr_src = ctl_q.src_ext ? pin_edge : cyc_tick;

    psc_wdt_base #(.BASE(WDT_BASE)) u_base (
        .clk(clk), .rst(rst), .clr(wdt_clr), .tick(wdt_tick), .expire_o(base_exp)
    );

    assign mask    = rate_mask(ctl_q.rate, ctl_q.own_wdt);
    assign pre_evt = ctl_q.own_wdt ? base_exp : tmr_src;
    assign pre_clr = tmr_wr | (wdt_clr & ctl_q.own_wdt);

    psc_divider #(.W(PRE_W)) u_div (
        .clk(clk), .rst(rst), .clr(pre_clr), .evt(pre_evt),
        .mask(mask), .pass_o(pre_pass)
    );

    assign tmr_inc = ctl_q.own_wdt ? tmr_src : pre_pass;

    psc_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst(rst), .wr(tmr_wr), .wdata(tmr_wdata),
        .inc(tmr_inc), .value(tmr_value), .ovf(tmr_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) wdt_timeout <= 1'b0;
        else     wdt_timeout <= ctl_q.own_wdt ? pre_pass : base_exp;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (ctl_value == 8'hFF && tmr_value == '0 && !tmr_ovf && !wdt_timeout));

    // R2
    ctl_write_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> (ctl_value == $past(ctl_wdata)));

    // R8
    timeout_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_timeout |-> $past(wdt_tick));

    // R11
    clear_blocks_timeout_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_clr |=> !wdt_timeout);

endmodule

// File: tb/tick_prescaler_top_tb.sv
module tick_prescaler_top_tb;
    localparam int CLK_NS   = 10;
    localparam int WDT_BASE = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_wr = 0, tmr_wr = 0, wdt_clr = 0, cyc_tick = 0, ext_pin = 0, wdt_tick = 0;
    logic [7:0] ctl_wdata = 0, tmr_wdata = 0;
    logic [7:0] ctl_value, tmr_value;
    logic tmr_ovf, wdt_timeout;

    always #(CLK_NS/2) clk = ~clk;

    tick_prescaler_top #(.WDT_BASE(WDT_BASE)) u_dut (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata), .wdt_clr(wdt_clr),
        .cyc_tick(cyc_tick), .ext_pin(ext_pin), .wdt_tick(wdt_tick),
        .ctl_value(ctl_value), .tmr_value(tmr_value),
        .tmr_ovf(tmr_ovf), .wdt_timeout(wdt_timeout)
    );

    int checks = 0, errors = 0;
    int ovf_seen = 0, to_seen = 0;
    logic ovf_prev = 0;

    // model state
    int m_tmr = 0, m_pre = 0, m_ovf = 0;
    logic m_own_wdt = 1;
    int   m_rate = 7;

    always @(negedge clk) begin
        if (!rst) begin
            if (tmr_ovf) ovf_seen++;
            if (wdt_timeout) to_seen++;
            if (tmr_ovf && ovf_prev) begin
                checks++; errors++;
                $display("FAIL R10 overflow pulse width act=2+ exp=1");
            end
            ovf_prev = tmr_ovf;
        end
    end

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
        end
    endtask

    function automatic int tmr_div(input int rate);
        return 2 << rate;
    endfunction

    function automatic int wdt_period(input int rate, input logic own);
        return own ? WDT_BASE * (1 << rate) : WDT_BASE;
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_event();
        if (!m_own_wdt) begin
            m_pre++;
            if (m_pre < tmr_div(m_rate)) return;
            m_pre = 0;
        end
        if (m_tmr == 255) begin m_tmr = 0; m_ovf++; end
        else m_tmr++;
    endtask

    task automatic set_ctl(input logic [7:0] v);
        @(negedge clk); ctl_wr = 1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 0;
        m_own_wdt = v[3]; m_rate = int'(v[2:0]);
    endtask

    task automatic write_tmr(input logic [7:0] v);
        @(negedge clk); tmr_wr = 1; tmr_wdata = v;
        @(negedge clk); tmr_wr = 0;
        m_tmr = v; m_pre = 0;
    endtask

    task automatic int_events(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cyc_tick = 1;
            @(negedge clk); cyc_tick = 0;
            model_event();
        end
    endtask

    task automatic ext_pairs(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_pin = 1; idle(4);
            ext_pin = 0; idle(4);
            model_event();
        end
    endtask

    task automatic wdt_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); wdt_tick = 1;
            @(negedge clk); wdt_tick = 0;
        end
    endtask

    task automatic clr_wdt();
        @(negedge clk); wdt_clr = 1;
        @(negedge clk); wdt_clr = 0;
    endtask

    initial begin : watchdog
        #(CLK_NS * 190000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int base_ovf, base_to, n, sel;
        logic [7:0] cv;
        void'($urandom(32'h5EED_0042));
        idle(3);
        @(negedge clk); rst = 0;
        @(negedge clk);

        // R1 reset state
        chk("R1 ctl", int'(ctl_value), 255);
        chk("R1 tmr", int'(tmr_value), 0);
        chk("R1 pulses", int'(tmr_ovf) + int'(wdt_timeout), 0);

        // R2 readback including stored-only bits
        set_ctl(8'hC5); idle(1);
        chk("R2 readback", int'(ctl_value), 8'hC5);

        // R3 internal source, pin ignored, 1:1 via watchdog ownership (R7)
        set_ctl(8'b0000_1000); write_tmr(8'h00);
        ext_pairs(3); m_tmr = 0; idle(2);
        chk("R3 pin ignored", int'(tmr_value), 0);
        int_events(5); idle(2);
        chk("R7 one to one", int'(tmr_value), 5);

        // R4 rising edges only, cyc_tick ignored
        set_ctl(8'b0010_1000); write_tmr(8'h00);
        int_events(4); m_tmr = 0; idle(2);
        chk("R4 tick ignored", int'(tmr_value), 0);
        @(negedge clk); ext_pin = 1; idle(6);
        chk("R4 rise counted", int'(tmr_value), 1);
        ext_pin = 0; idle(6);
        chk("R4 fall ignored", int'(tmr_value), 1);

        // R5 falling edges only
        set_ctl(8'b0011_1000); write_tmr(8'h00);
        @(negedge clk); ext_pin = 1; idle(6);
        chk("R5 rise ignored", int'(tmr_value), 0);
        ext_pin = 0; idle(6);
        chk("R5 fall counted", int'(tmr_value), 1);

        // R6 timer-side divisor at rate 0 and rate 7
        set_ctl(8'b0000_0000); write_tmr(8'h00);
        int_events(3); idle(2);
        chk("R6 div2", int'(tmr_value), 1);
        set_ctl(8'b0000_0111); write_tmr(8'h00);
        int_events(255); idle(2);
        chk("R6 div256 short", int'(tmr_value), 0);
        int_events(1); idle(2);
        chk("R6 div256 pass", int'(tmr_value), 1);

        // R9 write vs same-cycle event at 1:1
        set_ctl(8'b0000_1000); write_tmr(8'h20);
        @(negedge clk); tmr_wr = 1; tmr_wdata = 8'h10; cyc_tick = 1;
        @(negedge clk); tmr_wr = 0; cyc_tick = 0; idle(2);
        chk("R9 write wins", int'(tmr_value), 8'h10);
        // R9 write restarts prescaler at 1:2
        set_ctl(8'b0000_0000); write_tmr(8'h00);
        int_events(1);
        @(negedge clk); tmr_wr = 1; tmr_wdata = 8'h40; cyc_tick = 1;
        @(negedge clk); tmr_wr = 0; cyc_tick = 0;
        m_tmr = 8'h40; m_pre = 0;
        int_events(1); idle(2);
        chk("R9 prescaler restart", int'(tmr_value), 8'h40);

        // R10 overflow by count, not by write
        set_ctl(8'b0000_1000); write_tmr(8'hFE);
        base_ovf = ovf_seen;
        int_events(2); idle(2);
        chk("R10 wrap value", int'(tmr_value), 0);
        chk("R10 wrap pulse", ovf_seen - base_ovf, 1);
        write_tmr(8'hFF); write_tmr(8'h00); idle(2);
        chk("R10 write no pulse", ovf_seen - base_ovf, 1);

        // R11 clear does not touch timer-owned prescaler
        set_ctl(8'b0000_0000); write_tmr(8'h00);
        int_events(1); clr_wdt(); int_events(1); idle(2);
        chk("R11 timer prescaler kept", int'(tmr_value), 1);

        // R8 timeouts, watchdog not owning
        set_ctl(8'b0000_0101); clr_wdt();
        base_to = to_seen;
        wdt_ticks(WDT_BASE * 3 + 1); idle(3);
        chk("R8 base period", to_seen - base_to, 3);

        // R8 owned, rate 2
        set_ctl(8'b0000_1010); clr_wdt();
        base_to = to_seen;
        wdt_ticks(wdt_period(2, 1) * 2 - 1); idle(3);
        chk("R8 owned short", to_seen - base_to, 1);
        wdt_ticks(1); idle(3);
        chk("R8 owned full", to_seen - base_to, 2);

        // R11 clear with same-cycle tick, owned rate 0
        set_ctl(8'b0000_1000); clr_wdt();
        base_to = to_seen;
        wdt_ticks(WDT_BASE - 1);
        @(negedge clk); wdt_clr = 1; wdt_tick = 1;
        @(negedge clk); wdt_clr = 0; wdt_tick = 0;
        wdt_ticks(WDT_BASE - 1); idle(3);
        chk("R11 clear wins", to_seen - base_to, 0);
        wdt_ticks(1); idle(3);
        chk("R11 after clear", to_seen - base_to, 1);

        // random mix R3/R4/R6/R7/R10
        for (int it = 0; it < 24; it++) begin
            cv = 8'($urandom());
            cv[4] = 1'b0;
            set_ctl(cv);
            write_tmr(8'($urandom()));
            base_ovf = ovf_seen;
            m_ovf = 0;
            sel = int'($urandom_range(0, 3));
            if (cv[5]) begin
                n = int'($urandom_range(1, 150));
                ext_pairs(n);
            end else begin
                n = int'($urandom_range(1, 600));
                int_events(n);
            end
            idle(4);
            if (cv[3]) chk("R7 random count", int'(tmr_value), m_tmr);
            else       chk("R6 random count", int'(tmr_value), m_tmr);
            chk("R10 random pulses", ovf_seen - base_ovf, m_ovf);
            if (sel == 0) idle(1);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule